// File: doc/BRIEF.md
# Burst-of-Four Quad-Rate Synchronous SRAM Core

This block is a cycle-level, synthesizable model of a synchronous SRAM with separate read and write data paths. Read and write commands are active-low strobes sampled on the rising edge of the main clock, and they share one burst address. Each command moves four words over two clock periods. The double-rate data bus is shown as two lanes per clock: a "rise" lane for the beat on the clock's rising edge and a "fall" lane for the beat on the complementary clock's rising edge.

The burst address selects a group of four consecutive words. The two low bits of the word address give the beat index, which runs 0, 1, 2, 3. Write beats are committed to storage as they arrive, and an active-low per-byte mask gates every beat. Read bursts come out a fixed, parameterised number of clocks after the command, together with a valid flag. Read and write strobes are decoded independently. Each strobe is locked out for one edge after it is accepted, because a burst fills two clocks.

Top module: `qdr_sram_core`

## Requirements
- R1: After a synchronous active-low reset, `rd_valid` is 0, both read lanes are 0, and every storage word reads back as 0.
- R2: A clock edge with both `rd_cmd_n` and `wr_cmd_n` high is a no-operation. The address, data lanes and masks on that edge change neither storage nor the outputs.
- R3: A read strobe is accepted when it is low on an edge and no read was accepted on the previous edge. A low read strobe on the edge right after an accepted read is ignored.
- R4: A write strobe follows the same lockout rule. On the edge right after an accepted write, the strobe and address are ignored, and that edge's data lanes carry beats 2 and 3 of the earlier burst.
- R5: A write accepted on edge E with burst address A stores the rise lane to word {A,0} and the fall lane to word {A,1} on E. On E+1 it stores the rise lane to {A,2} and the fall lane to {A,3}.
- R6: The data width is a whole number of 9-bit bytes. This gives one mask bit at 9 bits, two at 18 bits and four at 36 bits. Mask bit i of a lane covers data bits [9i+8:9i] of that lane's beat. A 0 writes that byte and a 1 keeps the stored byte. The rise and fall masks are sampled on every write edge.
- R7: For a read accepted on edge E, with RD_LAT = L (default 2), the outputs after edge E+L show words {A,0} on the rise lane and {A,1} on the fall lane. After E+L+1 they show {A,2} and {A,3}. `rd_valid` is 1 in exactly those two cycles. In every other cycle it is 0 and both lanes are 0.
- R8: A read returns storage as it stood just before its own command edge. Beats written on that same edge or later are not seen, even when they arrive before the data is shown.
- R9: Read and write strobes on the same edge are both served, and each one keeps its own lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; commands and rise-lane beats are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| burst_addr | input | ADDR_W | Burst address, sampled with an accepted strobe |
| rd_cmd_n | input | 1 | Active-low read strobe |
| wr_cmd_n | input | 1 | Active-low write strobe |
| wdata_rise | input | DATA_W | Write beat of the rising-edge lane |
| wdata_fall | input | DATA_W | Write beat of the complementary-edge lane |
| wmask_rise_n | input | DATA_W/9 | Active-low byte enables for the rise-lane beat |
| wmask_fall_n | input | DATA_W/9 | Active-low byte enables for the fall-lane beat |
| rdata_rise | output | DATA_W | Read beat 0 or 2 |
| rdata_fall | output | DATA_W | Read beat 1 or 3 |
| rd_valid | output | 1 | High while read beats are presented |

## Verification
A behavioural model is compared against the outputs on every clock while several kinds of traffic run. A lone read of an address that was never written separates a correctly reset store from stale contents. Fully enabled writes check the beat order. Writes with masks that differ per lane and per edge expose any mask taken from the wrong beat. Strobes held low for two edges in a row show whether the lockout swallows the second one, and whether the write data on that edge still reaches beats 2 and 3. A read and a write on the same edge, and a read one edge after a write, pin down which storage snapshot a read sees. Long random mixes of reads, writes and no-operations then stress both lockouts at once.

// File: rtl/qdr_pkg.sv
// Package: shared constants and types for the quad-rate SRAM core.
// Assumes every burst holds four beats carried on two lanes per clock.
package qdr_pkg;
    localparam int BURST_LEN = 4;
    localparam int BEAT_BITS = 2;
    localparam int BYTE_BITS = 9;

    // Which half of a write burst the write path is in
    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } half_e;
endpackage

// File: rtl/qdr_cmd_gate.sv
// Module: strobe acceptance with one-edge lockout.
// Accepts an active-low strobe unless the previous edge already accepted
// one, since a burst fills two clocks. Assumes a synchronous active-low reset.
module qdr_cmd_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic accept
);
    logic lock_q;

    // Decide acceptance of the current strobe
    always_comb begin
        accept = !strobe_n && !lock_q;
    end

    // Remember an accepted strobe for one edge
    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= 1'b0;
        else        lock_q <= accept;
    end

    // R3 R4
    strobe_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);
endmodule

// File: rtl/qdr_wr_path.sv
// Module: write burst sequencer.
// On the command edge it issues beats 0 and 1. On the next edge it issues
// beats 2 and 3 at the saved base address. Active-low masks are turned
// into active-high byte enables. Assumes the command gate enforces the lockout.
module qdr_wr_path
    import qdr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 18,
    parameter int NBYTE  = 2,
    localparam int WORD_AW = ADDR_W + BEAT_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    d_rise,
    input  logic [DATA_W-1:0]    d_fall,
    input  logic [NBYTE-1:0]     m_rise_n,
    input  logic [NBYTE-1:0]     m_fall_n,
    output logic                 we,
    output logic [WORD_AW-1:0]   addr_a,
    output logic [WORD_AW-1:0]   addr_b,
    output logic [DATA_W-1:0]    data_a,
    output logic [DATA_W-1:0]    data_b,
    output logic [NBYTE-1:0]     be_a,
    output logic [NBYTE-1:0]     be_b
);
    half_e             phase_q;
    logic [ADDR_W-1:0] base_q;

    // Route this edge's two lanes to their word addresses
    always_comb begin
        we     = accept || (phase_q == PH_SECOND);
        data_a = d_rise;
        data_b = d_fall;
        be_a   = ~m_rise_n;
        be_b   = ~m_fall_n;
        if (phase_q == PH_SECOND) begin
            addr_a = {base_q, 2'd2};
            addr_b = {base_q, 2'd3};
        end else begin
            addr_a = {addr, 2'd0};
            addr_b = {addr, 2'd1};
        end
    end

    // Track the burst half and hold the base address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_FIRST;
            base_q  <= '0;
        end else begin
            phase_q <= accept ? PH_SECOND : PH_FIRST;
            if (accept) base_q <= addr;
        end
    end

    // R4
    wr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SECOND) |-> !accept);
endmodule

// File: rtl/qdr_store.sv
// Module: register-array storage with two byte-masked write ports and
// four read ports that return a whole burst combinationally.
// Assumes both write ports never target the same word on one edge.
module qdr_store
    import qdr_pkg::*;
#(
    parameter int AW     = 6,
    parameter int DATA_W = 18,
    parameter int NBYTE  = 2,
    localparam int DEPTH = 1 << AW
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                we,
    input  logic [AW-1:0]                       addr_a,
    input  logic [AW-1:0]                       addr_b,
    input  logic [DATA_W-1:0]                   data_a,
    input  logic [DATA_W-1:0]                   data_b,
    input  logic [NBYTE-1:0]                    be_a,
    input  logic [NBYTE-1:0]                    be_b,
    input  logic [BURST_LEN-1:0][AW-1:0]        rd_addr,
    output logic [BURST_LEN-1:0][DATA_W-1:0]    rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Clear on reset, else commit the enabled bytes of both beats
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
        end else if (we) begin
            for (int b = 0; b < NBYTE; b++) begin
                if (be_a[b]) mem[addr_a][b*BYTE_BITS +: BYTE_BITS] <= data_a[b*BYTE_BITS +: BYTE_BITS];
                if (be_b[b]) mem[addr_b][b*BYTE_BITS +: BYTE_BITS] <= data_b[b*BYTE_BITS +: BYTE_BITS];
            end
        end
    end

    // One read port for each beat of a burst
    for (genvar k = 0; k < BURST_LEN; k++) begin : g_rd
        assign rd_data[k] = mem[rd_addr[k]];
    end

    // R5
    port_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (addr_a != addr_b));
endmodule

// File: rtl/qdr_rd_pipe.sv
// Module: read latency pipeline and two-cycle beat presenter.
// Takes a four-word snapshot on the command edge, delays it RD_LAT edges,
// then shows beats 0/1 and then 2/3. Assumes accepted reads are at least
// two edges apart and RD_LAT >= 1.
module qdr_rd_pipe
    import qdr_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int RD_LAT = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             accept,
    input  logic [BURST_LEN-1:0][DATA_W-1:0] snap,
    output logic [DATA_W-1:0]                q_rise,
    output logic [DATA_W-1:0]                q_fall,
    output logic                             q_valid
);
    logic                             stg_v [RD_LAT];
    logic [BURST_LEN-1:0][DATA_W-1:0] stg_d [RD_LAT];
    logic [1:0][DATA_W-1:0]           tail_q;
    logic                             tail_v;

    // Carry snapshots down the latency stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < RD_LAT; i++) begin
                stg_v[i] <= 1'b0;
                stg_d[i] <= '0;
            end
        end else begin
            stg_v[0] <= accept;
            stg_d[0] <= snap;
            for (int i = 1; i < RD_LAT; i++) begin
                stg_v[i] <= stg_v[i-1];
                stg_d[i] <= stg_d[i-1];
            end
        end
    end

    // Show the first beat pair, then the held second pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_rise  <= '0;
            q_fall  <= '0;
            q_valid <= 1'b0;
            tail_q  <= '0;
            tail_v  <= 1'b0;
        end else if (stg_v[RD_LAT-1]) begin
            q_rise  <= stg_d[RD_LAT-1][0];
            q_fall  <= stg_d[RD_LAT-1][1];
            q_valid <= 1'b1;
            tail_q  <= {stg_d[RD_LAT-1][3], stg_d[RD_LAT-1][2]};
            tail_v  <= 1'b1;
        end else if (tail_v) begin
            q_rise  <= tail_q[0];
            q_fall  <= tail_q[1];
            q_valid <= 1'b1;
            tail_v  <= 1'b0;
        end else begin
            q_rise  <= '0;
            q_fall  <= '0;
            q_valid <= 1'b0;
        end
    end

    // R7
    burst_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_valid) |=> q_valid);

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |-> (q_rise == '0 && q_fall == '0));
endmodule

// File: rtl/qdr_sram_core.sv
// Module: top of the burst-of-four quad-rate SRAM core.
// Decodes the read and write strobes separately, sequences write bursts
// into storage, and pipelines read snapshots to the output lanes.
// Assumes DATA_W is 9, 18 or 36 and a synchronous active-low reset.
module qdr_sram_core
    import qdr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 18,
    parameter int RD_LAT = 2,
    localparam int NBYTE   = DATA_W / BYTE_BITS,
    localparam int WORD_AW = ADDR_W + BEAT_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] burst_addr,
    input  logic              rd_cmd_n,
    input  logic              wr_cmd_n,
    input  logic [DATA_W-1:0] wdata_rise,
    input  logic [DATA_W-1:0] wdata_fall,
    input  logic [NBYTE-1:0]  wmask_rise_n,
    input  logic [NBYTE-1:0]  wmask_fall_n,
    output logic [DATA_W-1:0] rdata_rise,
    output logic [DATA_W-1:0] rdata_fall,
    output logic              rd_valid
);
    logic                              rd_acc, wr_acc;
    logic                              st_we;
    logic [WORD_AW-1:0]                st_addr_a, st_addr_b;
    logic [DATA_W-1:0]                 st_data_a, st_data_b;
    logic [NBYTE-1:0]                  st_be_a, st_be_b;
    logic [BURST_LEN-1:0][WORD_AW-1:0] rd_addr;
    logic [BURST_LEN-1:0][DATA_W-1:0]  rd_snap;

    // R6
    initial begin
        width_rule_chk: assert (NBYTE * BYTE_BITS == DATA_W &&
                                (NBYTE == 1 || NBYTE == 2 || NBYTE == 4));
    end

    qdr_cmd_gate u_rd_gate (
        .clk(clk), .rst_n(rst_n), .strobe_n(rd_cmd_n), .accept(rd_acc)
    );

    qdr_cmd_gate u_wr_gate (
        .clk(clk), .rst_n(rst_n), .strobe_n(wr_cmd_n), .accept(wr_acc)
    );

    qdr_wr_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBYTE(NBYTE)) u_wr (
        .clk(clk), .rst_n(rst_n), .accept(wr_acc), .addr(burst_addr),
        .d_rise(wdata_rise), .d_fall(wdata_fall),
        .m_rise_n(wmask_rise_n), .m_fall_n(wmask_fall_n),
        .we(st_we), .addr_a(st_addr_a), .addr_b(st_addr_b),
        .data_a(st_data_a), .data_b(st_data_b),
        .be_a(st_be_a), .be_b(st_be_b)
    );

    // Word addresses of the four beats of the incoming read
    for (genvar k = 0; k < BURST_LEN; k++) begin : g_raddr
        assign rd_addr[k] = {burst_addr, 2'(k)};
    end

    qdr_store #(.AW(WORD_AW), .DATA_W(DATA_W), .NBYTE(NBYTE)) u_store (
        .clk(clk), .rst_n(rst_n), .we(st_we),
        .addr_a(st_addr_a), .addr_b(st_addr_b),
        .data_a(st_data_a), .data_b(st_data_b),
        .be_a(st_be_a), .be_b(st_be_b),
        .rd_addr(rd_addr), .rd_data(rd_snap)
    );

    qdr_rd_pipe #(.DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_rd (
        .clk(clk), .rst_n(rst_n), .accept(rd_acc), .snap(rd_snap),
        .q_rise(rdata_rise), .q_fall(rdata_fall), .q_valid(rd_valid)
    );

    // R9
    dual_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_cmd_n && !wr_cmd_n && !$past(rd_acc) && !$past(wr_acc)) |-> (rd_acc && wr_acc));
endmodule

// File: tb/qdr_sram_core_tb.sv
`timescale 1ns/1ps
module qdr_sram_core_tb;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 18;
    localparam int RD_LAT = 2;
    localparam int NB     = DATA_W / 9;
    localparam int WORDS  = 1 << (ADDR_W + 2);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] burst_addr = '0;
    logic              rd_cmd_n = 1'b1, wr_cmd_n = 1'b1;
    logic [DATA_W-1:0] wdata_rise = '0, wdata_fall = '0;
    logic [NB-1:0]     wmask_rise_n = '1, wmask_fall_n = '1;
    logic [DATA_W-1:0] rdata_rise, rdata_fall;
    logic              rd_valid;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    // reference model state
    logic [DATA_W-1:0] m_mem [WORDS];
    bit m_rlock = 0, m_wlock = 0, m_wpend = 0;
    int m_wbase = 0;
    int edge_n = 0;
    logic [DATA_W-1:0] ex_r [int];
    logic [DATA_W-1:0] ex_f [int];
    string ex_t [int];
    string cur_tag = "R1";

    always #4 clk = ~clk;

    qdr_sram_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .burst_addr(burst_addr),
        .rd_cmd_n(rd_cmd_n), .wr_cmd_n(wr_cmd_n),
        .wdata_rise(wdata_rise), .wdata_fall(wdata_fall),
        .wmask_rise_n(wmask_rise_n), .wmask_fall_n(wmask_fall_n),
        .rdata_rise(rdata_rise), .rdata_fall(rdata_fall), .rd_valid(rd_valid)
    );

    task automatic put_beat(input int word, input logic [DATA_W-1:0] d, input logic [NB-1:0] mn);
        for (int b = 0; b < NB; b++)
            if (!mn[b]) m_mem[word][b*9 +: 9] = d[b*9 +: 9];
    endtask

    task automatic compare(input int n);
        logic ev;
        logic [DATA_W-1:0] er, ef;
        string tg;
        ev = ex_t.exists(n);
        er = ev ? ex_r[n] : '0;
        ef = ev ? ex_f[n] : '0;
        tg = ev ? ex_t[n] : (n == 0 ? "R1" : "R7");
        compared++;
        if (rd_valid !== ev || rdata_rise !== er || rdata_fall !== ef) begin
            mismatched++;
            $display("FAIL %s edge %0d: got v=%b r=%h f=%h exp v=%b r=%h f=%h",
                     tg, n, rd_valid, rdata_rise, rdata_fall, ev, er, ef);
        end
    endtask

    // compare last edge's outputs, then drive and predict the next edge
    task automatic cycle(input bit rn, input bit wn, input int a,
                         input logic [DATA_W-1:0] dr, input logic [DATA_W-1:0] df,
                         input logic [NB-1:0] mr, input logic [NB-1:0] mf);
        bit racc, wacc;
        int e, base;
        @(negedge clk);
        compare(edge_n);
        rd_cmd_n = rn; wr_cmd_n = wn; burst_addr = ADDR_W'(a);
        wdata_rise = dr; wdata_fall = df; wmask_rise_n = mr; wmask_fall_n = mf;
        e = edge_n + 1;
        racc = !rn && !m_rlock; m_rlock = racc;
        wacc = !wn && !m_wlock; m_wlock = wacc;
        base = (a % (1 << ADDR_W)) * 4;
        if (racc) begin
            ex_r[e+RD_LAT] = m_mem[base];     ex_f[e+RD_LAT] = m_mem[base+1];
            ex_r[e+RD_LAT+1] = m_mem[base+2]; ex_f[e+RD_LAT+1] = m_mem[base+3];
            ex_t[e+RD_LAT] = cur_tag;         ex_t[e+RD_LAT+1] = cur_tag;
        end
        if (m_wpend) begin
            put_beat(m_wbase + 2, dr, mr);
            put_beat(m_wbase + 3, df, mf);
            m_wpend = 0;
        end
        if (wacc) begin
            put_beat(base, dr, mr);
            put_beat(base + 1, df, mf);
            m_wpend = 1;
            m_wbase = base;
        end
        edge_n = e;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1, 1, 0, '0, '0, '1, '1);
    endtask

    task automatic rd(input int a);
        cycle(0, 1, a, '0, '0, '1, '1);
        cycle(1, 1, 0, '0, '0, '1, '1);
    endtask

    task automatic wr(input int a, input logic [DATA_W-1:0] d0, input logic [DATA_W-1:0] d1,
                      input logic [DATA_W-1:0] d2, input logic [DATA_W-1:0] d3,
                      input logic [NB-1:0] m0, input logic [NB-1:0] m1,
                      input logic [NB-1:0] m2, input logic [NB-1:0] m3);
        cycle(1, 0, a, d0, d1, m0, m1);
        cycle(1, 1, 0, d2, d3, m2, m3);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        for (int w = 0; w < WORDS; w++) m_mem[w] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset outputs and zeroed storage
        cur_tag = "R1";
        rd(5); idle(4);

        // R5: full burst write then read back
        cur_tag = "R5";
        wr(3, 18'h00011, 18'h10022, 18'h20033, 18'h30044, '0, '0, '0, '0);
        idle(1); rd(3); idle(4);

        // R6: per-lane, per-edge byte masks
        cur_tag = "R6";
        wr(3, 18'h3ffff, 18'h2aaaa, 18'h15555, 18'h3ffff, 2'b01, 2'b10, 2'b11, 2'b00);
        idle(1); rd(3); idle(4);

        // R3: read strobe held for two edges, then back-to-back reads
        cur_tag = "R3";
        cycle(0, 1, 3, '0, '0, '1, '1);
        cycle(0, 1, 5, '0, '0, '1, '1);
        cycle(0, 1, 5, '0, '0, '1, '1);
        cycle(1, 1, 0, '0, '0, '1, '1);
        idle(4);

        // R4: write strobe held for two edges; second one ignored
        cur_tag = "R4";
        cycle(1, 0, 4, 18'h01234, 18'h05678, '0, '0);
        cycle(1, 0, 6, 18'h09abc, 18'h0def0, '0, '0);
        idle(1); rd(4); rd(6); idle(4);

        // R2: no-operation edges with busy address/data lanes
        cur_tag = "R2";
        for (int i = 0; i < 6; i++)
            cycle(1, 1, i, 18'($urandom), 18'($urandom), '0, '0);
        rd(3); rd(4); idle(4);

        // R8: same-edge read+write, and read one edge after a write
        cur_tag = "R8";
        cycle(0, 0, 3, 18'h11111, 18'h22222, '0, '0);
        cycle(1, 1, 0, 18'h33333, 18'h04444, '0, '0);
        idle(1); rd(3); idle(3);
        cycle(1, 0, 7, 18'h0aaaa, 18'h0bbbb, '0, '0);
        cycle(0, 1, 7, 18'h0cccc, 18'h0dddd, '0, '0);
        cycle(1, 1, 0, '0, '0, '1, '1);
        idle(2); rd(7); idle(4);

        // R9: random mixed traffic with both lockouts active
        cur_tag = "R9";
        for (int i = 0; i < 500; i++)
            cycle($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 15),
                  18'($urandom), 18'($urandom), 2'($urandom), 2'($urandom));
        idle(6);
        finished = 1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL R7 watchdog expired at edge %0d: got hang exp completion", edge_n);
            summary();
        end
    end
endmodule